// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block sequences one DRAM bank. A requester hands it column reads and writes, each naming a row and a column. The block turns each request into the device commands the bank needs: row activate, column read or write, and precharge. It tracks which row is held in the row buffer. Every accepted request is classified as a hit (its row is already open), an empty access (no row is open), or a conflict (a different row is open). The classification comes out in the acceptance cycle so that a scheduler above can use it.

The row-buffer policy is chosen at run time by `close_page`.
- With the policy low (open-page), the row stays open after the column command. A later hit to that row costs only a column command.
- With the policy high (close-page), every column command is followed at once by a precharge.

The bank keeps its own minimum spacings with dedicated down-counters: activate-to-activate, activate-to-column, precharge-to-activate, and write-to-read. A precharge-all input, meant for refresh, closes any open row and parks the bank idle.

Requests use a valid/ready handshake. A request transfers in a cycle where `req_valid` and `req_ready` are both high. `req_ready` never depends on `req_valid`. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. Commands leave as single-cycle codes on `cmd_op` with no back-pressure. All timing parameters must be at least 2.

Top module: `bank_row_ctrl`

## Requirements
- R1: After reset no row is open, `req_ready` is high and `cmd_op` shows NOP (code 0).
- R2: For an empty access, an activate (code 1) carrying the request row is issued in the cycle after acceptance; only R6 may delay it. The column command follows exactly T_RCD cycles after the activate unless R7 delays it, and it carries the request row and column.
- R3: Under open-page, a hit issues its column command (read code 2, write code 3) in the cycle after acceptance; only R7 may delay it. No activate or precharge is issued for a hit.
- R4: For a conflict, a precharge (code 4) is issued in the cycle after acceptance. The activate follows exactly T_RP cycles after the precharge unless R6 pushes it later, and the column command then follows as in R2.
- R5: Under close-page, a precharge is issued in the cycle after every column command, so the next request is classified empty.
- R6: Two activates are at least T_RC cycles apart. An activate held back only by this rule issues in the first cycle it is allowed.
- R7: A read column command comes at least T_WTR cycles after the last write column command. A read held back only by this rule issues in the first cycle it is allowed.
- R8: While `pre_all` is high, `req_ready` is low. A row left open by open-page is closed by exactly one precharge in the cycle after `pre_all` is first seen, and no other command follows while it is held. After release, the next request is classified empty.
- R9: Raising `close_page` while an open-page bank holds a row with no work pending issues a precharge in the next cycle.
- R10: `req_class` is valid in the acceptance cycle: 0 for empty, 1 for hit, 2 for conflict.
- R11: `req_ready` rises in the cycle after a column command when a row stays open. Otherwise it rises T_RP cycles after the closing precharge. It is low in all other cycles while work is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_page | input | 1 | Policy select: 1 close-page, 0 open-page |
| pre_all | input | 1 | Precharge-all request (refresh) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_class | output | 2 | Classification of the request being accepted |
| cmd_op | output | 3 | Command code: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE |
| cmd_row | output | ROW_W | Row carried by ACT, RD, WR, PRE |
| cmd_col | output | COL_W | Column carried by RD and WR |

## Verification
The bench builds the block with 3-bit rows and columns. This makes every ordered pair of rows reachable, under each policy and with every read/write mix of the pair, in a few thousand cycles. T_RC is 9, longer than the shortest path from one activate to the next. Both the close-page loop and the open-page conflict path therefore stall on the activate spacing. T_WTR is 4, longer than the hit latency, so a read hit that follows a write waits visibly. T_RCD of 3 and T_RP of 2 sit at or near the minimum, which exercises the look-ahead exit from the activate and precharge waits.

// File: rtl/bank_ctrl_pkg.sv
package bank_ctrl_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic [1:0] {
    CLS_EMPTY    = 2'd0,
    CLS_HIT      = 2'd1,
    CLS_CONFLICT = 2'd2
  } row_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_ACTIVATING,
    ST_PRECHARGING,
    ST_COLUMN
  } bank_state_e;
endpackage

// File: rtl/spacing_timer.sv
module spacing_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] left
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign left = cnt_q;
endmodule

// File: rtl/open_row_tracker.sv
module open_row_tracker
  import bank_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic             close_en,
  input  logic [ROW_W-1:0] probe_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic [1:0]       probe_cls
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_en) begin
      open_q <= 1'b1;
      row_q  <= open_row_in;
    end else if (close_en) begin
      open_q <= 1'b0;
    end
  end

  always_comb begin
    if (!open_q)                 probe_cls = CLS_EMPTY;
    else if (row_q == probe_row) probe_cls = CLS_HIT;
    else                         probe_cls = CLS_CONFLICT;
  end

  assign is_open  = open_q;
  assign open_row = row_q;

  // R4
  act_pre_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_en && close_en));
endmodule

// File: rtl/bank_row_ctrl.sv
module bank_row_ctrl
  import bank_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 6,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 10,
  parameter int unsigned T_WTR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_page,
  input  logic             pre_all,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [1:0]       req_class,
  output logic [2:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col
);
  localparam int unsigned M1    = (T_RC > T_RCD) ? T_RC : T_RCD;
  localparam int unsigned M2    = (T_RP > T_WTR) ? T_RP : T_WTR;
  localparam int unsigned T_MAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam int unsigned NTMR  = 4;
  localparam int unsigned GAP [NTMR] = '{T_RC, T_RCD, T_RP, T_WTR};

  bank_state_e      state_q;
  logic             sent_q, chain_q, pend_write_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;

  logic             issue_act, issue_pre, issue_col, accept;
  logic             trc_ok, rcd_near, rp_near, wtr_ok;
  logic             row_is_open;
  logic [ROW_W-1:0] open_row;
  logic [1:0]       cls;
  logic [NTMR-1:0]  tmr_load;
  logic [TW-1:0]    tmr_left [NTMR];
  bank_cmd_e        cmd_e;

  // Spacing counters: 0 act-to-act, 1 act-to-column, 2 pre-to-act, 3 write-to-read
  assign tmr_load = {issue_col && pend_write_q, issue_pre, issue_act, issue_act};

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    spacing_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load[g]),
      .load_val (TW'(GAP[g] - 1)),
      .left     (tmr_left[g])
    );
  end

  assign trc_ok   = (tmr_left[0] == '0);
  assign rcd_near = (tmr_left[1] <= TW'(1));
  assign rp_near  = (tmr_left[2] <= TW'(1));
  assign wtr_ok   = (tmr_left[3] == '0);

  open_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_en     (issue_act),
    .open_row_in (pend_row_q),
    .close_en    (issue_pre),
    .probe_row   (req_row),
    .is_open     (row_is_open),
    .open_row    (open_row),
    .probe_cls   (cls)
  );

  assign issue_act = (state_q == ST_ACTIVATING) && !sent_q && trc_ok;
  assign issue_pre = (state_q == ST_PRECHARGING) && !sent_q;
  assign issue_col = (state_q == ST_COLUMN) && (pend_write_q || wtr_ok);
  assign req_ready = !pre_all &&
                     ((state_q == ST_IDLE) || ((state_q == ST_ACTIVE) && !close_page));
  assign accept    = req_valid && req_ready;
  assign req_class = cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      sent_q       <= 1'b0;
      chain_q      <= 1'b0;
      pend_write_q <= 1'b0;
      pend_row_q   <= '0;
      pend_col_q   <= '0;
    end else begin
      if (accept) begin
        pend_write_q <= req_write;
        pend_row_q   <= req_row;
        pend_col_q   <= req_col;
      end
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ACTIVATING;
          sent_q  <= 1'b0;
        end
        ST_ACTIVE: begin
          if (pre_all || close_page) begin
            state_q <= ST_PRECHARGING;
            sent_q  <= 1'b0;
            chain_q <= 1'b0;
          end else if (accept) begin
            sent_q  <= 1'b0;
            chain_q <= 1'b1;
            state_q <= (cls == CLS_HIT) ? ST_COLUMN : ST_PRECHARGING;
          end
        end
        ST_ACTIVATING: begin
          if (!sent_q) begin
            if (issue_act) sent_q <= 1'b1;
          end else if (rcd_near) begin
            state_q <= ST_COLUMN;
          end
        end
        ST_COLUMN: if (issue_col) begin
          if (close_page) begin
            state_q <= ST_PRECHARGING;
            sent_q  <= 1'b0;
            chain_q <= 1'b0;
          end else begin
            state_q <= ST_ACTIVE;
          end
        end
        ST_PRECHARGING: begin
          if (!sent_q) begin
            sent_q <= 1'b1;
          end else if (rp_near) begin
            state_q <= chain_q ? ST_ACTIVATING : ST_IDLE;
            sent_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_e   = CMD_NOP;
    cmd_row = '0;
    cmd_col = '0;
    if (issue_act) begin
      cmd_e   = CMD_ACT;
      cmd_row = pend_row_q;
    end else if (issue_pre) begin
      cmd_e   = CMD_PRE;
      cmd_row = open_row;
    end else if (issue_col) begin
      cmd_e   = pend_write_q ? CMD_WR : CMD_RD;
      cmd_row = pend_row_q;
      cmd_col = pend_col_q;
    end
  end
  assign cmd_op = cmd_e;

  // Cycle distance since the last command of each kind, for the spacing checks
  localparam int unsigned SW = TW + 1;
  logic [SW-1:0] since_act, since_pre, since_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_wr  <= '1;
    end else begin
      since_act <= (cmd_e == CMD_ACT) ? SW'(1) : ((since_act == '1) ? since_act : since_act + SW'(1));
      since_pre <= (cmd_e == CMD_PRE) ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + SW'(1));
      since_wr  <= (cmd_e == CMD_WR)  ? SW'(1) : ((since_wr  == '1) ? since_wr  : since_wr  + SW'(1));
    end
  end

  // R6
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_ACT) |-> (since_act >= SW'(T_RC)));
  // R2
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_RD || cmd_e == CMD_WR) |-> (since_act >= SW'(T_RCD)));
  // R4
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_ACT) |-> (since_pre >= SW'(T_RP)));
  // R7
  wtr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_RD) |-> (since_wr >= SW'(T_WTR)));
  // R3
  col_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_RD || cmd_e == CMD_WR) |-> (row_is_open && open_row == cmd_row));
  // R5
  close_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_e == CMD_RD || cmd_e == CMD_WR) && close_page) |=> (cmd_op == 3'd4));
  // R8
  pa_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> !req_ready);
  // R9
  policy_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && close_page) |=> (cmd_op == 3'd4));
endmodule

// File: tb/tb_bank_row_ctrl.sv
`timescale 1ns/1ps
module tb_bank_row_ctrl;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;
  localparam int T_RC  = 9;
  localparam int T_WTR = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, close_page, pre_all, req_valid, req_write;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             req_ready;
  logic [1:0]       req_class;
  logic [2:0]       cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  bank_row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
                  .T_RC(T_RC), .T_WTR(T_WTR)) dut (
    .clk(clk), .rst_n(rst_n), .close_page(close_page), .pre_all(pre_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_class(req_class),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Command monitor
  int t_act = -1000, t_pre = -1000, t_col = -1000, t_wr = -1000;
  int n_act = 0, n_pre = 0, n_col = 0;
  int act_row = 0, col_row = 0, col_col = 0, col_op = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      case (cmd_op)
        3'd1: begin t_act = cyc; act_row = cmd_row; n_act++; end
        3'd4: begin t_pre = cyc; n_pre++; end
        3'd2, 3'd3: begin
          t_col = cyc; col_row = cmd_row; col_col = cmd_col; col_op = cmd_op; n_col++;
          if (cmd_op == 3'd3) t_wr = cyc;
        end
        default: ;
      endcase
    end
  end

  bit m_open = 1'b0;
  int m_row = 0;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_req(input bit w, input int row, input int col);
    int drive_c, acc_c, cls, exp_cls, base, exp_act, exp_pre, exp_col;
    int pa, pw, pp, pc, nact0, npre0, ncol0, npre1;
    bit pol;
    pol = close_page;
    pa = t_act; pw = t_wr; pp = t_pre; pc = t_col;
    nact0 = n_act; npre0 = n_pre; ncol0 = n_col;
    exp_cls = !m_open ? 0 : ((m_row == row) ? 1 : 2);
    base = m_open ? pc + 1 : pp + T_RP;
    req_valid = 1'b1; req_write = w; req_row = ROW_W'(row); req_col = COL_W'(col);
    drive_c = cyc;
    #0.1;
    while (!req_ready) begin tick(); #0.1; end
    acc_c = cyc; cls = req_class;
    tick();
    req_valid = 1'b0;
    check_eq("R11 accept cycle", acc_c, imax(drive_c, base));
    check_eq("R10 class", cls, exp_cls);
    while (n_col == ncol0) tick();
    if (exp_cls == 1) begin
      exp_col = w ? acc_c + 1 : imax(acc_c + 1, pw + T_WTR);
      check_eq("R3 no act on hit", n_act, nact0);
      check_eq("R3 no pre on hit", n_pre, npre0);
      check_eq("R3 R7 hit column cycle", t_col, exp_col);
    end else begin
      if (exp_cls == 2) begin
        exp_pre = acc_c + 1;
        check_eq("R4 conflict pre cycle", t_pre, exp_pre);
        exp_act = imax(exp_pre + T_RP, pa + T_RC);
        check_eq("R4 R6 act cycle", t_act, exp_act);
      end else begin
        exp_act = imax(acc_c + 1, pa + T_RC);
        check_eq("R2 R6 act cycle", t_act, exp_act);
      end
      check_eq("R2 act row", act_row, row);
      exp_col = w ? exp_act + T_RCD : imax(exp_act + T_RCD, pw + T_WTR);
      check_eq("R2 R7 column cycle", t_col, exp_col);
    end
    check_eq("R2 column row", col_row, row);
    check_eq("R2 column col", col_col, col);
    check_eq("R3 column op", col_op, w ? 3 : 2);
    if (pol) begin
      npre1 = n_pre;
      while (n_pre == npre1) tick();
      check_eq("R5 close pre cycle", t_pre, t_col + 1);
      m_open = 1'b0;
    end else begin
      m_open = 1'b1;
      m_row = row;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int k, np0, na0, nc0;
    rst_n = 1'b0; close_page = 1'b0; pre_all = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_row = '0; req_col = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check_eq("R1 ready", int'(req_ready), 1);
    check_eq("R1 cmd", int'(cmd_op), 0);
    check_eq("R1 class", int'(req_class), 0);

    // Open-page sweep over all row pairs and read/write mixes (R2 R3 R4 R6 R7 R10 R11)
    for (int r1 = 0; r1 < 8; r1++)
      for (int r2 = 0; r2 < 8; r2++)
        for (int wm = 0; wm < 4; wm++) begin
          do_req(wm[0], r1, r2);
          do_req(wm[1], r2, r1);
        end

    // R9 policy switch closes the open row
    tick(); tick();
    np0 = n_pre; k = cyc;
    close_page = 1'b1;
    while (n_pre == np0) tick();
    check_eq("R9 pre cycle", t_pre, k + 1);
    m_open = 1'b0;

    // Close-page sweep (R5)
    for (int r1 = 0; r1 < 8; r1++)
      for (int r2 = 0; r2 < 8; r2++)
        for (int wm = 0; wm < 4; wm++) begin
          do_req(wm[0], r1, r2);
          do_req(wm[1], r2, r1);
        end

    // R8 precharge-all with a row open
    close_page = 1'b0;
    do_req(1'b1, 5, 2);
    tick(); tick();
    np0 = n_pre; na0 = n_act; nc0 = n_col; k = cyc;
    pre_all = 1'b1;
    #0.5;
    check_eq("R8 ready low", int'(req_ready), 0);
    repeat (10) tick();
    check_eq("R8 single pre", n_pre, np0 + 1);
    check_eq("R8 pre cycle", t_pre, k + 1);
    check_eq("R8 no act", n_act, na0);
    check_eq("R8 no column", n_col, nc0);
    check_eq("R8 ready held low", int'(req_ready), 0);
    pre_all = 1'b0;
    m_open = 1'b0;
    do_req(1'b0, 5, 1);
    check_eq("R8 row reopened", m_row, 5);
    repeat (4) tick();
    summary();
    $finish;
  end
endmodule